// File: doc/BRIEF.md
# Masked Vector Element Unit

This block runs elementwise vector operations over a small register file, one element per clock, under a one-bit-per-element mask. One operation sets every mask bit. Another compares each element of a source register against a scalar and writes the results into the mask. The rest are additions and moves whose result reaches the destination only where the mask bit is set. An element whose mask bit is clear acts as a bubble and its destination keeps its old value.

A mode pin, sampled when a command is accepted, picks how masked work is scheduled. In stepped mode every element below the vector length takes one cycle, and the mask only gates writeback. In packed mode the unit scans the mask and spends cycles only on set elements, so run time follows the number of active elements. Register and mask contents after any command do not depend on the mode.

Commands arrive on a valid/ready port. `cmd_ready` is high only while the unit is idle. A command is taken on the rising edge where `cmd_valid` and `cmd_ready` are both high. The sender must hold the command fields stable until that edge and may change them freely afterwards. Back-pressure lasts from the cycle after acceptance until the `done` cycle. An observation port returns one whole register, chosen by `rd_sel`, without delay.

Top module: `masked_vec_unit`

## Requirements
- R1: `cmd_ready` is low from the cycle after a command is accepted until `done` is high. `done` is high for exactly one cycle, in the cycle after the last processing cycle, and `cmd_ready` is high again in that same cycle.
- R2: Opcode 0 sets all 8 mask bits, leaves every vector register unchanged, and takes 1 processing cycle.
- R3: Opcode 1 sets mask bit i to (element i of vs1 > scalar, unsigned) for every i below VL. Mask bits at VL and above keep their values. The compare itself is not masked.
- R4: Opcodes 2, 3, 4 and 5 write vd[i] = vs1[i]+vs2[i], vs1[i]+scalar, vs1[i] and scalar respectively. Sums wrap at 8 bits.
- R5: During opcodes 2 to 5, an element whose mask bit is 0 keeps its old destination value, and the mask itself does not change.
- R6: Elements at index VL and above are never written. A VL above 8 is treated as 8, and VL 0 writes nothing.
- R7: In stepped mode (`dense_mode`=0), opcodes 1 to 5 take max(VL,1) processing cycles.
- R8: In packed mode (`dense_mode`=1), opcodes 2 to 5 take max(number of set mask bits below VL, 1) processing cycles. Opcode 1 takes max(VL,1).
- R9: The same command sequence leaves identical register and mask contents in both modes.
- R10: After reset all vector elements and all mask bits are 0, `done` is 0 and `cmd_ready` is 1. `rd_vec` holds element i of register `rd_sel` in bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| cmd_op | input | 3 | Opcode (0 set mask, 1 compare, 2..5 arithmetic/move) |
| cmd_vd | input | 2 | Destination register |
| cmd_vs1 | input | 2 | First source register |
| cmd_vs2 | input | 2 | Second source register |
| cmd_scalar | input | 8 | Scalar operand |
| cmd_vl | input | 4 | Vector length, 0..8 (larger values clamp to 8) |
| dense_mode | input | 1 | 1 = packed scheduling, 0 = stepped |
| done | output | 1 | One-cycle completion pulse |
| mask_out | output | 8 | Current mask register |
| rd_sel | input | 2 | Register chosen for observation |
| rd_vec | output | 64 | Contents of register `rd_sel` |

## Verification
A command accepted at rising edge k with N processing cycles writes its last element at edge k+N and raises `done` at that edge. The bench therefore counts the falling edges after acceptance, up to the first one where `done` is high, and compares that count with N worked out from VL, the opcode and the popcount of the mask. Registers and the mask are read through `rd_vec` and `mask_out` in the low half of the `done` cycle, when every write of the command has already landed. The sweep covers all 256 mask patterns and VL values 0 to 9 in both modes, and the final state of the two modes is compared.

// File: rtl/mvu_pkg.sv
`timescale 1ns/1ps
package mvu_pkg;
  localparam logic [2:0] OP_SETALL = 3'd0;
  localparam logic [2:0] OP_CMPGT  = 3'd1;
  localparam logic [2:0] OP_ADDVV  = 3'd2;
  localparam logic [2:0] OP_ADDVS  = 3'd3;
  localparam logic [2:0] OP_MOVV   = 3'd4;
  localparam logic [2:0] OP_MOVS   = 3'd5;
endpackage

// File: rtl/mvu_elem_alu.sv
`timescale 1ns/1ps
module mvu_elem_alu #(
  parameter int EW = 8
) (
  input  logic [2:0]    op,
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [EW-1:0] s,
  output logic [EW-1:0] res,
  output logic          gt,
  output logic          writes
);
  import mvu_pkg::*;

  always_comb begin
    gt     = (a > s);
    writes = 1'b1;
    case (op)
      OP_ADDVV: res = a + b;
      OP_ADDVS: res = a + s;
      OP_MOVV:  res = a;
      OP_MOVS:  res = s;
      default: begin
        res    = a;
        writes = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/mvu_first_set.sv
`timescale 1ns/1ps
module mvu_first_set #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_scan
    assign onehot[i]  = pend[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | pend[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mvu_vrf.sv
`timescale 1ns/1ps
module mvu_vrf #(
  parameter int NREG  = 4,
  parameter int NELEM = 8,
  parameter int EW    = 8,
  localparam int RW = $clog2(NREG),
  localparam int IW = $clog2(NELEM)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [RW-1:0]       wreg,
  input  logic [IW-1:0]       widx,
  input  logic [EW-1:0]       wdata,
  input  logic [RW-1:0]       ra_reg,
  input  logic [RW-1:0]       rb_reg,
  input  logic [IW-1:0]       r_idx,
  output logic [EW-1:0]       ra_data,
  output logic [EW-1:0]       rb_data,
  input  logic [RW-1:0]       rv_reg,
  output logic [NELEM*EW-1:0] rv_data
);
  logic [EW-1:0] mem [NREG][NELEM];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++)
        for (int e = 0; e < NELEM; e++)
          mem[r][e] <= '0;
    end else if (we) begin
      mem[wreg][widx] <= wdata;
    end
  end

  assign ra_data = mem[ra_reg][r_idx];
  assign rb_data = mem[rb_reg][r_idx];

  always_comb begin
    for (int e = 0; e < NELEM; e++)
      rv_data[e*EW +: EW] = mem[rv_reg][e];
  end
endmodule

// File: rtl/masked_vec_unit.sv
`timescale 1ns/1ps
module masked_vec_unit #(
  parameter int NREG  = 4,
  parameter int NELEM = 8,
  parameter int EW    = 8,
  localparam int RW  = $clog2(NREG),
  localparam int IW  = $clog2(NELEM),
  localparam int VLW = $clog2(NELEM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_op,
  input  logic [RW-1:0]       cmd_vd,
  input  logic [RW-1:0]       cmd_vs1,
  input  logic [RW-1:0]       cmd_vs2,
  input  logic [EW-1:0]       cmd_scalar,
  input  logic [VLW-1:0]      cmd_vl,
  input  logic                dense_mode,
  output logic                done,
  output logic [NELEM-1:0]    mask_out,
  input  logic [RW-1:0]       rd_sel,
  output logic [NELEM*EW-1:0] rd_vec
);
  import mvu_pkg::*;

  logic             busy_q, done_q;
  logic [2:0]       op_q;
  logic [RW-1:0]    vd_q, vs1_q, vs2_q;
  logic [EW-1:0]    scal_q;
  logic [NELEM-1:0] pend_q, wen_q, mask_q;
  logic [VLW-1:0]   vl_q, cyc_q;

  logic             accept;
  logic [VLW-1:0]   vl_eff;
  logic [NELEM-1:0] vl_bits, pend_init, wen_init;

  assign cmd_ready = ~busy_q;
  assign accept    = cmd_valid & ~busy_q;
  assign vl_eff    = (cmd_vl > VLW'(NELEM)) ? VLW'(NELEM) : cmd_vl;

  always_comb begin
    for (int i = 0; i < NELEM; i++)
      vl_bits[i] = (VLW'(i) < vl_eff);
  end

  // Work list and write enables captured at acceptance
  always_comb begin
    case (cmd_op)
      OP_SETALL: begin
        pend_init = '0;
        wen_init  = '0;
      end
      OP_CMPGT: begin
        pend_init = vl_bits;
        wen_init  = '1;
      end
      default: begin
        wen_init  = mask_q & vl_bits;
        pend_init = dense_mode ? (mask_q & vl_bits) : vl_bits;
      end
    endcase
  end

  // Element selection
  logic [NELEM-1:0] cur_oh, pend_nxt;
  logic [IW-1:0]    cur_idx;
  logic             cur_any, last;

  mvu_first_set #(.N(NELEM)) u_pick (
    .pend   (pend_q),
    .onehot (cur_oh),
    .idx    (cur_idx),
    .any    (cur_any)
  );

  assign pend_nxt = pend_q & ~cur_oh;
  assign last     = busy_q & (pend_nxt == '0);

  // Datapath
  logic [EW-1:0] a_elem, b_elem, res;
  logic          gt, alu_writes, rf_we;

  mvu_elem_alu #(.EW(EW)) u_alu (
    .op     (op_q),
    .a      (a_elem),
    .b      (b_elem),
    .s      (scal_q),
    .res    (res),
    .gt     (gt),
    .writes (alu_writes)
  );

  assign rf_we = busy_q & cur_any & (op_q != OP_CMPGT) & (op_q != OP_SETALL)
               & wen_q[cur_idx] & alu_writes;

  mvu_vrf #(.NREG(NREG), .NELEM(NELEM), .EW(EW)) u_vrf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .wreg    (vd_q),
    .widx    (cur_idx),
    .wdata   (res),
    .ra_reg  (vs1_q),
    .rb_reg  (vs2_q),
    .r_idx   (cur_idx),
    .ra_data (a_elem),
    .rb_data (b_elem),
    .rv_reg  (rd_sel),
    .rv_data (rd_vec)
  );

  // Control
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_SETALL;
      vd_q   <= '0;
      vs1_q  <= '0;
      vs2_q  <= '0;
      scal_q <= '0;
      pend_q <= '0;
      wen_q  <= '0;
      mask_q <= '0;
      vl_q   <= '0;
      cyc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        op_q   <= cmd_op;
        vd_q   <= cmd_vd;
        vs1_q  <= cmd_vs1;
        vs2_q  <= cmd_vs2;
        scal_q <= cmd_scalar;
        vl_q   <= vl_eff;
        pend_q <= pend_init;
        wen_q  <= wen_init;
        cyc_q  <= '0;
      end else if (busy_q) begin
        pend_q <= pend_nxt;
        cyc_q  <= cyc_q + 1'b1;
        if (op_q == OP_SETALL) mask_q <= '1;
        if (op_q == OP_CMPGT && cur_any) mask_q[cur_idx] <= gt;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign mask_out = mask_q;

  // Checks
  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_setall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_SETALL) |=> (mask_out == '1));

  assert_mask_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q >= OP_ADDVV) |=> $stable(mask_out));

  assert_vl_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (VLW'(cur_idx) < vl_q));

  assert_cycle_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cyc_q <= ((vl_q == '0) ? VLW'(1) : vl_q)));

  assert_single_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> $onehot0(cur_oh));
endmodule

// File: tb/masked_vec_unit_tb_top.sv
`timescale 1ns/1ps
module masked_vec_unit_tb_top;
  localparam int NREG = 4, NELEM = 8, EW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_vd = '0, cmd_vs1 = '0, cmd_vs2 = '0;
  logic [7:0] cmd_scalar = '0;
  logic [3:0] cmd_vl = '0;
  logic dense_mode = 1'b0;
  logic done;
  logic [7:0] mask_out;
  logic [1:0] rd_sel = '0;
  logic [63:0] rd_vec;

  always #2.5 clk = ~clk;

  masked_vec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_vd(cmd_vd), .cmd_vs1(cmd_vs1), .cmd_vs2(cmd_vs2),
    .cmd_scalar(cmd_scalar), .cmd_vl(cmd_vl), .dense_mode(dense_mode),
    .done(done), .mask_out(mask_out), .rd_sel(rd_sel), .rd_vec(rd_vec)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] mreg [NREG][NELEM];
  logic [7:0] mmask;
  logic [63:0] fin0 [NREG];
  logic [7:0]  fin0_mask;

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] packed_reg(input int r);
    logic [63:0] v;
    for (int e = 0; e < NELEM; e++) v[e*8 +: 8] = mreg[r][e];
    return v;
  endfunction

  // Call in the low half of a cycle; finishes before the next rising edge
  task automatic check_state(input string req);
    for (int r = 0; r < NREG; r++) begin
      rd_sel = 2'(r);
      #0.4;
      check_eq(req, rd_vec, packed_reg(r));
    end
    check_eq(req, {56'd0, mask_out}, {56'd0, mmask});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < NREG; r++)
      for (int e = 0; e < NELEM; e++) mreg[r][e] = 8'd0;
    mmask = 8'd0;
    // R10: reset state
    check_eq("R10", {62'd0, done, cmd_ready}, {62'd0, 1'b0, 1'b1});
    check_state("R10");
  endtask

  task automatic do_op(input logic [2:0] op, input int vd, input int vs1, input int vs2,
                       input logic [7:0] s, input int vl, input bit dens, input string req);
    int vle, n_exp, cnt, pc;
    logic [7:0] old_mask;
    vle = (vl > NELEM) ? NELEM : vl;
    pc = 0;
    for (int i = 0; i < vle; i++) if (mmask[i]) pc++;
    if (op == 3'd0) n_exp = 1;
    else if (op == 3'd1 || !dens) n_exp = (vle == 0) ? 1 : vle;
    else n_exp = (pc == 0) ? 1 : pc;

    @(negedge clk);
    cmd_op = op; cmd_vd = 2'(vd); cmd_vs1 = 2'(vs1); cmd_vs2 = 2'(vs2);
    cmd_scalar = s; cmd_vl = 4'(vl); dense_mode = dens; cmd_valid = 1'b1;
    @(posedge clk);
    cnt = 0;
    forever begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (done) break;
      if (cmd_ready) begin
        checks++; errors++;
        $display("FAIL R1: actual ready 1 expected 0 while busy at %0t", $time);
      end
      cnt++;
      if (cnt > 40) break;
    end
    check_eq(op == 3'd0 ? "R2" : (dens ? "R8" : "R7"), 64'(cnt), 64'(n_exp));
    // R1: ready returns in the done cycle
    check_eq("R1", {63'd0, cmd_ready}, 64'd1);

    old_mask = mmask;
    case (op)
      3'd0: mmask = 8'hFF;
      3'd1: for (int i = 0; i < vle; i++) mmask[i] = (mreg[vs1][i] > s);
      default: begin
        for (int i = 0; i < vle; i++) begin
          if (old_mask[i]) begin
            case (op)
              3'd2: mreg[vd][i] = mreg[vs1][i] + mreg[vs2][i];
              3'd3: mreg[vd][i] = mreg[vs1][i] + s;
              3'd4: mreg[vd][i] = mreg[vs1][i];
              default: mreg[vd][i] = s;
            endcase
          end
        end
      end
    endcase
    check_state(req);
  endtask

  task automatic sweep(input bit dens);
    for (int m = 0; m < 256; m++) begin
      do_op(3'd0, 0, 0, 0, 8'd0, 8, dens, "R2");
      // Load register 3 with the bits of m, longest prefix first (R6 prefix writes)
      for (int L = NELEM; L >= 1; L--)
        do_op(3'd5, 3, 0, 0, {7'd0, m[L-1]}, L, dens, "R6");
      do_op(3'd1, 0, 3, 0, 8'd0, 8, dens, "R3");
      // Masked arithmetic under mask m, VL 0..9 (R4, R5, R6)
      do_op(3'(2 + (m % 4)), m % 3, (m >> 2) % 4, 3, 8'(m * 37 + 11), m % 10, dens, "R5");
      if (m % 5 == 0)
        do_op(3'd3, (m >> 3) % 3, (m >> 1) % 3, 3, 8'(m * 13 + 200), 8, dens, "R4");
    end
  endtask

  initial begin
    #900000;
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // Directed: compare with short VL leaves upper mask bits (R3)
    do_op(3'd0, 0, 0, 0, 8'd0, 8, 1'b0, "R2");
    do_op(3'd5, 1, 0, 0, 8'd250, 8, 1'b0, "R4");
    do_op(3'd5, 1, 0, 0, 8'd5, 2, 1'b0, "R6");
    do_op(3'd1, 0, 1, 0, 8'd100, 3, 1'b0, "R3");
    check_eq("R3", {56'd0, mask_out}, {56'd0, 8'b1111_1100});
    // Density mode with three active elements of VL 5
    do_op(3'd3, 2, 1, 0, 8'd10, 5, 1'b1, "R8");
    // VL above 8 clamps
    do_op(3'd0, 0, 0, 0, 8'd0, 8, 1'b1, "R2");
    do_op(3'd2, 0, 1, 1, 8'd0, 12, 1'b1, "R6");

    do_reset();
    sweep(1'b0);
    for (int r = 0; r < NREG; r++) fin0[r] = packed_reg(r);
    fin0_mask = mmask;

    do_reset();
    sweep(1'b1);
    @(negedge clk);
    // R9: final state matches the stepped-mode run
    for (int r = 0; r < NREG; r++) begin
      rd_sel = 2'(r);
      #0.4;
      check_eq("R9", rd_vec, fin0[r]);
    end
    check_eq("R9", {56'd0, mask_out}, {56'd0, fin0_mask});

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule